// File: doc/BRIEF.md
# Aligned Write Burst Splitter

This block sits between a write initiator and the interconnect, on the write address, write data and write response channels of an AXI4-style port. It accepts one incrementing write burst of up to 256 beats and sends it downstream as a run of sub-bursts. Each sub-burst carries at most 16 beats and never crosses a 16-beat address boundary. The first sub-burst therefore runs from the start address up to the next boundary, and every later one starts on a boundary.

The beats of one sub-burst are collected in a local 16-entry buffer before its address goes out. The interconnect never holds an accepted address while it waits for slow upstream data. The sub-burst's beats then drain back to back, and the next sub-burst does not start filling until the previous one has fully drained. The downstream responses are counted and merged, and one response carrying the most severe code goes back upstream once every sub-burst has answered. Only one upstream burst is handled at a time. Every beat is full bus width and the address is beat aligned.

Top module: `burst_chopper`

## Requirements
- R1: While reset is held and right after it is released, `s_awready` is 1 and `s_wready`, `m_awvalid`, `m_wvalid` and `s_bvalid` are 0.
- R2: An upstream address is taken only when no burst is in progress. While a burst is in progress `s_awready` stays 0, and an `s_awvalid` offered then has no effect on the burst. Upstream write data offered with no burst in progress is not accepted (`s_wready` is 0).
- R3: Every downstream sub-burst has between 1 and 16 beats, and `m_awlen` equals its beat count minus one.
- R4: With B = 4 bytes per beat, no sub-burst crosses a 64-byte boundary. The first sub-burst covers min(16 - (start/B mod 16), remaining) beats from the start address. Each later sub-burst starts at the previous address plus its beat count times B.
- R5: The sub-bursts together carry exactly `s_awlen`+1 beats. The downstream data equals the upstream data in the same order.
- R6: A sub-burst's address is presented only after all of its beats have been accepted upstream. No further upstream beat is accepted between that point and the end of the sub-burst's drain.
- R7: `m_wlast` is 1 exactly on the final beat of each sub-burst. No beat of a sub-burst is sent before its address handshake, and no address is sent while beats of the previous sub-burst are still pending.
- R8: Exactly one upstream response is raised, and only after the downstream responses of all sub-bursts have been received. `m_bready` is always 1.
- R9: The upstream response code is the numerically largest code among the sub-burst responses (OKAY=0, EXOKAY=1, SLVERR=2, DECERR=3).
- R10: Once `m_awvalid` is raised it stays 1, with `m_awaddr` and `m_awlen` unchanged, until `m_awready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Upstream burst address valid |
| s_awready | output | 1 | Upstream burst address accepted |
| s_awaddr | input | ADDR_W | Upstream burst start byte address, beat aligned |
| s_awlen | input | LEN_W | Upstream burst beat count minus one |
| s_wvalid | input | 1 | Upstream data beat valid |
| s_wready | output | 1 | Upstream data beat accepted |
| s_wdata | input | DATA_W | Upstream data beat |
| s_bvalid | output | 1 | Merged response valid |
| s_bready | input | 1 | Merged response accepted |
| s_bresp | output | 2 | Merged response code |
| m_awvalid | output | 1 | Sub-burst address valid |
| m_awready | input | 1 | Sub-burst address accepted |
| m_awaddr | output | ADDR_W | Sub-burst start byte address |
| m_awlen | output | LEN_W | Sub-burst beat count minus one |
| m_wvalid | output | 1 | Sub-burst data beat valid |
| m_wready | input | 1 | Sub-burst data beat accepted |
| m_wdata | output | DATA_W | Sub-burst data beat |
| m_wlast | output | 1 | Final beat of the sub-burst |
| m_bvalid | input | 1 | Sub-burst response valid |
| m_bready | output | 1 | Sub-burst response accepted |
| m_bresp | input | 2 | Sub-burst response code |

## Verification
The response for one sub-burst can arrive in the same cycle as the address handshake of the next sub-burst. In that cycle the outstanding count must be raised and lowered at once. The bench makes this happen by sweeping the downstream response delay from zero to three cycles, using one-beat and boundary-straddling sub-bursts and throttled ready patterns, so that response returns land on address handshakes. It judges the outcome by when the single upstream response appears and by the code it carries. An upstream response raised early, or never raised, shows that the count slipped.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_ADDR,
        ST_DRAIN,
        ST_RESP
    } chop_state_e;

endpackage

// File: rtl/chop_planner.sv
// Length of the next sub-burst: the smaller of the beats left before the
// next aligned boundary and the beats still owed for the whole burst.
module chop_planner #(
    parameter int ADDR_W   = 32,
    parameter int BEAT_LSB = 2,
    parameter int SUB_W    = 4,
    parameter int REM_W    = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [REM_W-1:0]  remain,
    output logic [SUB_W:0]    len
);
    localparam int SUB_MAX = 1 << SUB_W;

    logic [SUB_W-1:0] slot;
    logic [SUB_W:0]   room;

    always_comb begin
        slot = addr[BEAT_LSB+SUB_W-1:BEAT_LSB];
        room = (SUB_W+1)'(SUB_MAX) - {1'b0, slot};
        if (remain < REM_W'(room)) begin
            len = remain[SUB_W:0];
        end else begin
            len = room;
        end
    end
endmodule

// File: rtl/chop_beat_buf.sv
module chop_beat_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [PTR_W:0]    count
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [PTR_W:0]   cnt;
    } buf_t;

    buf_t buf_d, buf_q;
    logic [DATA_W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        buf_d = buf_q;
        if (push) begin
            buf_d.wr = bump(buf_q.wr);
        end
        if (pop) begin
            buf_d.rd = bump(buf_q.rd);
        end
        if (push && !pop) begin
            buf_d.cnt = buf_q.cnt + 1'b1;
        end else if (pop && !push) begin
            buf_d.cnt = buf_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[buf_q.wr] <= din;
        end
    end

    assign dout  = mem[buf_q.rd];
    assign count = buf_q.cnt;

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (buf_q.cnt < (PTR_W+1)'(DEPTH)));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (buf_q.cnt != '0));
endmodule

// File: rtl/chop_resp_merge.sv
module chop_resp_merge #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       issue,
    input  logic       b_fire,
    input  logic [1:0] b_resp,
    output logic       done,
    output logic [1:0] worst
);
    typedef struct packed {
        logic [CNT_W-1:0] pending;
        logic [1:0]       worst;
    } mrg_t;

    mrg_t mrg_d, mrg_q;

    always_comb begin
        mrg_d = mrg_q;
        if (clear) begin
            mrg_d = '0;
        end else begin
            if (issue && !b_fire) begin
                mrg_d.pending = mrg_q.pending + 1'b1;
            end else if (b_fire && !issue) begin
                mrg_d.pending = mrg_q.pending - 1'b1;
            end
            if (b_fire && (b_resp > mrg_q.worst)) begin
                mrg_d.worst = b_resp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrg_q <= '0;
        end else begin
            mrg_q <= mrg_d;
        end
    end

    assign done  = (mrg_q.pending == '0);
    assign worst = mrg_q.worst;

    // R8
    resp_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_fire |-> (mrg_q.pending != '0));
endmodule

// File: rtl/burst_chopper.sv
module burst_chopper
    import chop_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 8,
    parameter int MAX_SUB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [LEN_W-1:0]  s_awlen,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [LEN_W-1:0]  m_awlen,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic              m_wlast,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [1:0]        m_bresp
);
    localparam int SUB_W    = $clog2(MAX_SUB);
    localparam int REM_W    = LEN_W + 1;
    localparam int BEAT_LSB = $clog2(DATA_W / 8);
    localparam int CNT_W    = $clog2(((1 << LEN_W) / MAX_SUB) + 2) + 1;

    typedef struct packed {
        chop_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [REM_W-1:0]  remain;
        logic [SUB_W:0]    sub_len;
        logic [SUB_W:0]    cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] nxt_addr, plan_addr;
    logic [REM_W-1:0]  nxt_rem, plan_rem;
    logic [SUB_W:0]    plan_len;
    logic [SUB_W:0]    buf_count;
    logic [DATA_W-1:0] buf_dout;
    logic              w_push, w_pop, aw_take, aw_issue, b_fire;
    logic              resp_done;
    logic [1:0]        resp_worst;

    // Where the following sub-burst starts and how much is left after it.
    assign nxt_addr  = ctl_q.addr + (ADDR_W'(ctl_q.sub_len) << BEAT_LSB);
    assign nxt_rem   = ctl_q.remain - REM_W'(ctl_q.sub_len);
    assign plan_addr = (ctl_q.state == ST_IDLE) ? s_awaddr : nxt_addr;
    assign plan_rem  = (ctl_q.state == ST_IDLE) ? (REM_W'(s_awlen) + 1'b1) : nxt_rem;

    chop_planner #(
        .ADDR_W  (ADDR_W),
        .BEAT_LSB(BEAT_LSB),
        .SUB_W   (SUB_W),
        .REM_W   (REM_W)
    ) u_planner (
        .addr  (plan_addr),
        .remain(plan_rem),
        .len   (plan_len)
    );

    chop_beat_buf #(
        .DATA_W(DATA_W),
        .DEPTH (MAX_SUB)
    ) u_buf (
        .clk  (clk),
        .rst_n(rst_n),
        .push (w_push),
        .din  (s_wdata),
        .pop  (w_pop),
        .dout (buf_dout),
        .count(buf_count)
    );

    chop_resp_merge #(
        .CNT_W(CNT_W)
    ) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (aw_take),
        .issue (aw_issue),
        .b_fire(b_fire),
        .b_resp(m_bresp),
        .done  (resp_done),
        .worst (resp_worst)
    );

    assign s_awready = (ctl_q.state == ST_IDLE);
    assign s_wready  = (ctl_q.state == ST_FILL);
    assign m_awvalid = (ctl_q.state == ST_ADDR);
    assign m_awaddr  = ctl_q.addr;
    assign m_awlen   = LEN_W'(ctl_q.sub_len - 1'b1);
    assign m_wvalid  = (ctl_q.state == ST_DRAIN);
    assign m_wdata   = buf_dout;
    assign m_wlast   = (ctl_q.state == ST_DRAIN) && (ctl_q.cnt == ctl_q.sub_len - 1'b1);
    assign m_bready  = 1'b1;
    assign s_bvalid  = (ctl_q.state == ST_RESP) && resp_done;
    assign s_bresp   = resp_worst;

    assign aw_take  = s_awvalid && s_awready;
    assign w_push   = s_wvalid && s_wready;
    assign w_pop    = m_wvalid && m_wready;
    assign aw_issue = m_awvalid && m_awready;
    assign b_fire   = m_bvalid && m_bready;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (s_awvalid) begin
                    ctl_d.addr    = s_awaddr;
                    ctl_d.remain  = plan_rem;
                    ctl_d.sub_len = plan_len;
                    ctl_d.cnt     = '0;
                    ctl_d.state   = ST_FILL;
                end
            end
            ST_FILL: begin
                if (w_push) begin
                    if (ctl_q.cnt + 1'b1 == ctl_q.sub_len) begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_ADDR;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            ST_ADDR: begin
                if (m_awready) begin
                    ctl_d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (w_pop) begin
                    if (m_wlast) begin
                        ctl_d.addr    = nxt_addr;
                        ctl_d.remain  = nxt_rem;
                        ctl_d.sub_len = plan_len;
                        ctl_d.cnt     = '0;
                        ctl_d.state   = (nxt_rem == '0) ? ST_RESP : ST_FILL;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            ST_RESP: begin
                if (s_bvalid && s_bready) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R3
    sub_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (m_awlen < LEN_W'(MAX_SUB)));

    // R4
    boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> ((REM_W'(m_awaddr[BEAT_LSB+SUB_W-1:BEAT_LSB]) + REM_W'(m_awlen))
                       < REM_W'(MAX_SUB)));

    // R6
    data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (REM_W'(buf_count) == REM_W'(m_awlen) + 1'b1));

    // R7
    drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && m_wready && m_wlast) |=> (buf_count == '0));

    // R10
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr) && $stable(m_awlen)));
endmodule

// File: tb/burst_chopper_test.sv
module burst_chopper_test;
    localparam int NV = 7;

    // stimulus and expected results, one column per vector
    localparam logic [31:0] V_ADDR  [NV] = '{32'h0, 32'h10, 32'h3C, 32'h3C, 32'h1000, 32'h104, 32'h20};
    localparam int          V_LEN   [NV] = '{15, 15, 0, 1, 255, 255, 40};
    localparam int          V_ERR   [NV] = '{-1, 1, -1, 0, 15, 16, 2};
    localparam int          V_CODE  [NV] = '{0, 2, 0, 3, 2, 3, 1};
    localparam int          V_EX    [NV] = '{-1, 0, 0, 1, -1, 3, -1};
    localparam int          V_STALL [NV] = '{0, 1, 0, 0, 1, 0, 1};
    localparam int          V_GAP   [NV] = '{0, 1, 0, 0, 0, 1, 1};
    localparam int          V_BDLY  [NV] = '{0, 2, 0, 1, 3, 0, 1};
    localparam int          V_NSUB  [NV] = '{1, 2, 1, 2, 16, 17, 4};
    localparam int          V_BRESP [NV] = '{0, 2, 1, 3, 2, 3, 1};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        s_awvalid, s_awready;
    logic [31:0] s_awaddr;
    logic [7:0]  s_awlen;
    logic        s_wvalid, s_wready;
    logic [31:0] s_wdata;
    logic        s_bvalid, s_bready;
    logic [1:0]  s_bresp;
    logic        m_awvalid, m_awready;
    logic [31:0] m_awaddr;
    logic [7:0]  m_awlen;
    logic        m_wvalid, m_wready;
    logic [31:0] m_wdata;
    logic        m_wlast;
    logic        m_bvalid, m_bready;
    logic [1:0]  m_bresp;

    always #4 clk = ~clk;

    burst_chopper uut (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awlen(s_awlen),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wlast(m_wlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // state of the downstream model
    bit          run = 0;
    int          cur = 0;
    int          exp_n;
    logic [31:0] exp_addr [20];
    int          exp_len  [20];
    int          exp_cum  [20];
    int          aw_seen, beat_in_sub, w_total, up_beats, bq, bwait, b_done, cyc;
    bit          aw_wait;
    logic [31:0] held_addr;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int resp_for(input int j);
        if (j == V_ERR[cur]) return V_CODE[cur];
        if (j == V_EX[cur]) return 1;
        return 0;
    endfunction

    // downstream model: ready patterns, response return, checks per handshake
    initial begin
        m_awready = 1'b1;
        m_wready  = 1'b1;
        m_bvalid  = 1'b0;
        m_bresp   = 2'd0;
        forever begin
            @(negedge clk);
            if (run) begin
                cyc++;
                if (m_bvalid && m_bready) begin
                    bq--;
                    b_done++;
                    bwait = 0;
                end
                m_awready = !(V_STALL[cur] != 0 && (cyc % 3) == 0);
                m_wready  = !(V_STALL[cur] != 0 && (cyc % 2) == 0);
                if (bq > 0 && bwait >= V_BDLY[cur]) begin
                    m_bvalid = 1'b1;
                    m_bresp  = 2'(resp_for(b_done));
                end else begin
                    m_bvalid = 1'b0;
                    if (bq > 0) bwait++;
                    else bwait = 0;
                end
                if (aw_wait) begin
                    // R10: held address stays put until accepted
                    chk(m_awvalid && m_awaddr == held_addr, "R10", "awaddr held",
                        m_awaddr, held_addr);
                end
                if (m_awvalid && m_awready) begin
                    aw_wait = 0;
                    chk(aw_seen < exp_n, "R5", "extra sub-burst", aw_seen, exp_n);
                    if (aw_seen < exp_n) begin
                        chk(m_awaddr == exp_addr[aw_seen], "R4", "sub address",
                            m_awaddr, exp_addr[aw_seen]);
                        chk(int'(m_awlen) == exp_len[aw_seen] - 1, "R3", "awlen",
                            m_awlen, exp_len[aw_seen] - 1);
                        chk(up_beats == exp_cum[aw_seen], "R6", "beats held before address",
                            up_beats, exp_cum[aw_seen]);
                        chk(w_total == exp_cum[aw_seen] - exp_len[aw_seen], "R7",
                            "previous sub drained", w_total, exp_cum[aw_seen] - exp_len[aw_seen]);
                    end
                    aw_seen++;
                    beat_in_sub = 0;
                end else if (m_awvalid) begin
                    aw_wait   = 1;
                    held_addr = m_awaddr;
                end else begin
                    aw_wait = 0;
                end
                if (m_wvalid && m_wready) begin
                    chk(aw_seen > 0, "R7", "data before address", aw_seen, 1);
                    chk(m_wdata == ((cur << 16) + w_total), "R5", "data order",
                        m_wdata, (cur << 16) + w_total);
                    if (aw_seen > 0) begin
                        chk(m_wlast == (beat_in_sub == exp_len[aw_seen-1] - 1), "R7", "wlast",
                            m_wlast, beat_in_sub == exp_len[aw_seen-1] - 1);
                        if (m_wlast) bq++;
                    end
                    beat_in_sub++;
                    w_total++;
                end
            end else begin
                m_awready = 1'b1;
                m_wready  = 1'b1;
                m_bvalid  = 1'b0;
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic feed(input int n, input int v);
        for (int i = 0; i < n; i++) begin
            if (V_GAP[v] != 0 && (i % 5) == 2) begin
                s_wvalid = 1'b0;
                @(negedge clk);
            end
            s_wvalid = 1'b1;
            s_wdata  = (v << 16) + i;
            while (!s_wready) @(negedge clk);
            @(posedge clk);
            up_beats++;
            @(negedge clk);
        end
        s_wvalid = 1'b0;
    endtask

    task automatic plan(input int v);
        logic [31:0] sa;
        int rem, n, room, acc;
        sa  = V_ADDR[v];
        rem = V_LEN[v] + 1;
        acc = 0;
        exp_n = 0;
        while (rem > 0) begin
            room = 16 - int'((sa >> 2) & 32'hF);
            n = (rem < room) ? rem : room;
            acc += n;
            exp_addr[exp_n] = sa;
            exp_len[exp_n]  = n;
            exp_cum[exp_n]  = acc;
            exp_n++;
            sa  += 32'(n * 4);
            rem -= n;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        s_awvalid = 1'b0; s_awaddr = '0; s_awlen = '0;
        s_wvalid = 1'b0; s_wdata = '0; s_bready = 1'b0;
        repeat (3) @(posedge clk);
        step();
        chk(s_awready == 1'b1 && s_wready == 1'b0, "R1", "ready in reset",
            {s_awready, s_wready}, 2'b10);
        chk(!m_awvalid && !m_wvalid && !s_bvalid, "R1", "valids in reset",
            {m_awvalid, m_wvalid, s_bvalid}, 0);
        rst_n = 1'b1;
        step();
        chk(s_awready == 1'b1 && !m_awvalid && !m_wvalid && !s_bvalid, "R1", "after release",
            {s_awready, m_awvalid, m_wvalid, s_bvalid}, 4'b1000);

        // R2: stray data with no burst open is refused and leaves no trace
        s_wvalid = 1'b1;
        s_wdata  = 32'hBAD0BAD0;
        repeat (3) begin
            step();
            chk(s_wready == 1'b0, "R2", "stray data refused", s_wready, 0);
        end
        s_wvalid = 1'b0;

        for (int v = 0; v < NV; v++) begin
            cur = v;
            plan(v);
            chk(exp_n == V_NSUB[v], "R4", "table sub count", exp_n, V_NSUB[v]);
            aw_seen = 0; beat_in_sub = 0; w_total = 0; up_beats = 0;
            bq = 0; bwait = 0; b_done = 0; cyc = 0; aw_wait = 0;
            run = 1;
            @(negedge clk);
            s_awvalid = 1'b1;
            s_awaddr  = V_ADDR[v];
            s_awlen   = 8'(V_LEN[v]);
            while (!s_awready) @(negedge clk);
            @(posedge clk);
            step();
            // R2: a second address offered mid-burst is ignored
            s_awaddr = 32'hDEAD0000;
            s_awlen  = 8'd3;
            chk(s_awready == 1'b0, "R2", "busy refuses address", s_awready, 0);
            feed(V_LEN[v] + 1, v);
            chk(s_awready == 1'b0, "R2", "still busy", s_awready, 0);
            s_awvalid = 1'b0;
            while (!s_bvalid) step();
            chk(b_done == exp_n, "R8", "responses before merge", b_done, exp_n);
            chk(m_bready == 1'b1, "R8", "bready", m_bready, 1);
            chk(int'(s_bresp) == V_BRESP[v], "R9", "merged code", s_bresp, V_BRESP[v]);
            chk(aw_seen == exp_n, "R5", "sub count", aw_seen, exp_n);
            chk(w_total == V_LEN[v] + 1, "R5", "beat total", w_total, V_LEN[v] + 1);
            step();
            chk(s_bvalid == 1'b1, "R8", "response held", s_bvalid, 1);
            s_bready = 1'b1;
            @(posedge clk);
            step();
            s_bready = 1'b0;
            chk(s_bvalid == 1'b0 && s_awready == 1'b1, "R8", "single response",
                {s_bvalid, s_awready}, 2'b01);
            run = 0;
        end

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule